// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition flags of a small accumulator-style processor core. Each cycle it can take one ALU operation: an operation code and the two operands. From these it works out carry, half carry, zero and overflow, and it updates only the flags that the operation class affects. Software can write the four arithmetic flags directly. A direct write wins over an ALU update that arrives in the same cycle.

Two further flags record the power and watchdog history of the core. Four single-cycle strobes drive them: power-up, watchdog clear, halt and watchdog time-out. A small state machine holds these two flags. Its states are PW_RUN (both clear), PW_HALT (power-down flag set), PW_WDT_RUN (time-out flag set) and PW_WDT_HALT (both set). It has the following transitions:

- Power-up goes to PW_RUN.
- Otherwise, halt goes to PW_HALT and watchdog clear goes to PW_RUN. Any other cycle keeps the present state.
- A time-out in the same cycle then moves the chosen state to its time-out twin.

The status word is read back as eight bits, with the top two bits always zero. Interrupt entry and subroutine calls do not save this word, so firmware must save it if it needs it.

Top module: `status_flags`

## Requirements
- R1: The codes ADD (1) and ADC (2) form a + b + cin, where cin is 0 for ADD and the current C for ADC. C (bit 0) takes the carry out of the full width. AC (bit 1) takes the carry out of the low four bits.
- R2: The codes SUB (3) and SBC (4) form a - b - borrow, where borrow is 0 for SUB and the inverse of the current C for SBC. C is set when no borrow leaves the full width. AC is set when no borrow crosses from the high nibble into the low nibble.
- R3: For codes 1 to 4, OV (bit 3) is set when the signed result is out of range, that is, when the carry into the top bit differs from the carry out of it. Otherwise OV is cleared.
- R4: Codes 1 to 7 set Z (bit 2) when the 8-bit result is zero and clear it otherwise.
- R5: The logic codes AND (5), OR (6) and XOR (7) change only Z. C, AC and OV keep their values.
- R6: The rotate-through-carry codes change only C. RLC (8) loads C from bit 7 of a. RRC (9) loads C from bit 0 of a.
- R7: With wr_en high, bits 0 to 3 take wr_data in the next cycle. Bits 4 and 5 are not changed by the write.
- R8: When a write and an ALU operation arrive in the same cycle, bits 0 to 3 take the write data.
- R9: PDF (bit 4) is cleared by pwr_up or wdt_clr and is set by halt_cmd. If halt_cmd and wdt_clr arrive together, halt_cmd wins.
- R10: TO (bit 5) is cleared by pwr_up, wdt_clr or halt_cmd and is set by wdt_tmo. A time-out beats wdt_clr and halt_cmd in the same cycle, but pwr_up beats everything.
- R11: After reset the status word is 0, and bits 6 and 7 always read 0.
- R12: Code NONE (0), and the unused codes 10 to 15, leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 4 | ALU operation code for this cycle |
| alu_a | input | DATA_W | First operand (rotate source) |
| alu_b | input | DATA_W | Second operand |
| wr_en | input | 1 | Direct write of the arithmetic flags |
| wr_data | input | 4 | New values for bits 0 to 3 |
| pwr_up | input | 1 | Power-up event strobe |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| halt_cmd | input | 1 | Halt instruction strobe |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| status | output | 8 | Status word readback |

## Verification
The bench builds the block with the default DATA_W of 8 and AUX_W of 4, so the carry, half-carry and overflow boundaries sit at the familiar operand values 0x0F, 0x7F, 0x80 and 0xFF. Reaching those boundaries puts every sign-overflow and nibble-carry corner within a few directed operations. With this 8-bit width the bench's expected flags come from plain integer and signed arithmetic, so no carry-chain logic is copied. All four power states and every pairing of events that can happen at once can be reached with short strobe sequences.

// File: rtl/sf_pkg.sv
package sf_pkg;

    localparam int FLAG_C        = 0;
    localparam int FLAG_AC       = 1;
    localparam int FLAG_Z        = 2;
    localparam int FLAG_OV       = 3;
    localparam int NUM_ALU_FLAGS = 4;
    localparam int STAT_W        = 8;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SUB  = 4'd3,
        OP_SBC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_RLC  = 4'd8,
        OP_RRC  = 4'd9
    } alu_op_e;

    // bit 0 of the state is the power-down flag, bit 1 the time-out flag
    typedef enum logic [1:0] {
        PW_RUN      = 2'b00,
        PW_HALT     = 2'b01,
        PW_WDT_RUN  = 2'b10,
        PW_WDT_HALT = 2'b11
    } pwr_state_e;

endpackage

// File: rtl/sf_flag_eval.sv
module sf_flag_eval
    import sf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AUX_W  = 4
) (
    input  logic [3:0]               op,
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  logic                     cur_c,
    output logic [NUM_ALU_FLAGS-1:0] upd,
    output logic [NUM_ALU_FLAGS-1:0] nxt
);

    localparam int BODY_W = DATA_W - 1;

    logic              is_arith, is_sub, use_c, is_logic, is_rlc, is_rrc;
    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W:0]   sum_full;
    logic [AUX_W:0]    sum_low;
    logic [BODY_W:0]   sum_body;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] result;

    // decode of the operation class
    always_comb begin
        is_arith = 1'b0;
        is_sub   = 1'b0;
        use_c    = 1'b0;
        is_logic = 1'b0;
        is_rlc   = 1'b0;
        is_rrc   = 1'b0;
        logic_res = '0;
        unique case (alu_op_e'(op))
            OP_ADD: is_arith = 1'b1;
            OP_ADC: begin is_arith = 1'b1; use_c = 1'b1; end
            OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_SBC: begin is_arith = 1'b1; is_sub = 1'b1; use_c = 1'b1; end
            OP_AND: begin is_logic = 1'b1; logic_res = a & b; end
            OP_OR:  begin is_logic = 1'b1; logic_res = a | b; end
            OP_XOR: begin is_logic = 1'b1; logic_res = a ^ b; end
            OP_RLC: is_rlc = 1'b1;
            OP_RRC: is_rrc = 1'b1;
            default: ;
        endcase
    end

    // subtraction is done as addition of the complement, so the
    // carry out is the inverse of the borrow
    always_comb begin
        b_eff    = is_sub ? ~b : b;
        cin      = use_c ? cur_c : is_sub;
        sum_full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum_low  = {1'b0, a[AUX_W-1:0]} + {1'b0, b_eff[AUX_W-1:0]}
                 + {{AUX_W{1'b0}}, cin};
        sum_body = {1'b0, a[BODY_W-1:0]} + {1'b0, b_eff[BODY_W-1:0]}
                 + {{BODY_W{1'b0}}, cin};
        result   = is_logic ? logic_res : sum_full[DATA_W-1:0];
    end

    always_comb begin
        upd = '0;
        nxt = '0;
        if (is_arith) begin
            upd          = '1;
            nxt[FLAG_C]  = sum_full[DATA_W];
            nxt[FLAG_AC] = sum_low[AUX_W];
            nxt[FLAG_OV] = sum_body[BODY_W] ^ sum_full[DATA_W];
            nxt[FLAG_Z]  = (result == '0);
        end else if (is_logic) begin
            upd[FLAG_Z] = 1'b1;
            nxt[FLAG_Z] = (result == '0);
        end else if (is_rlc) begin
            upd[FLAG_C] = 1'b1;
            nxt[FLAG_C] = a[DATA_W-1];
        end else if (is_rrc) begin
            upd[FLAG_C] = 1'b1;
            nxt[FLAG_C] = a[0];
        end
    end

endmodule

// File: rtl/sf_arith_reg.sv
module sf_arith_reg
    import sf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [NUM_ALU_FLAGS-1:0] wr_data,
    input  logic [NUM_ALU_FLAGS-1:0] upd,
    input  logic [NUM_ALU_FLAGS-1:0] nxt,
    output logic [NUM_ALU_FLAGS-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ALU_FLAGS; gi++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[gi] <= 1'b0;
                end else if (wr_en) begin
                    q[gi] <= wr_data[gi];
                end else if (upd[gi]) begin
                    q[gi] <= nxt[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sf_pwr_fsm.sv
module sf_pwr_fsm
    import sf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic wdt_clr,
    input  logic halt_cmd,
    input  logic wdt_tmo,
    output logic pdf,
    output logic tmo_flag
);

    pwr_state_e state, base, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_RUN;
        end else begin
            state <= state_nxt;
        end
    end

    // first the instruction effect, then a time-out on top
    always_comb begin
        base = state;
        if (halt_cmd) begin
            base = PW_HALT;
        end else if (wdt_clr) begin
            base = PW_RUN;
        end
        state_nxt = base;
        if (pwr_up) begin
            state_nxt = PW_RUN;
        end else if (wdt_tmo) begin
            unique case (base)
                PW_RUN:      state_nxt = PW_WDT_RUN;
                PW_HALT:     state_nxt = PW_WDT_HALT;
                PW_WDT_RUN:  state_nxt = PW_WDT_RUN;
                PW_WDT_HALT: state_nxt = PW_WDT_HALT;
                default:     state_nxt = PW_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        pdf      = 1'b0;
        tmo_flag = 1'b0;
        unique case (state)
            PW_RUN:      ;
            PW_HALT:     pdf = 1'b1;
            PW_WDT_RUN:  tmo_flag = 1'b1;
            PW_WDT_HALT: begin pdf = 1'b1; tmo_flag = 1'b1; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/status_flags.sv
module status_flags
    import sf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AUX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               alu_op,
    input  logic [DATA_W-1:0]        alu_a,
    input  logic [DATA_W-1:0]        alu_b,
    input  logic                     wr_en,
    input  logic [NUM_ALU_FLAGS-1:0] wr_data,
    input  logic                     pwr_up,
    input  logic                     wdt_clr,
    input  logic                     halt_cmd,
    input  logic                     wdt_tmo,
    output logic [STAT_W-1:0]        status
);

    localparam int PAD_W = STAT_W - NUM_ALU_FLAGS - 2;

    logic [NUM_ALU_FLAGS-1:0] flag_q, flag_upd, flag_nxt;
    logic                     pdf, tmo_flag;

    sf_flag_eval #(.DATA_W(DATA_W), .AUX_W(AUX_W)) i_eval (
        .op    (alu_op),
        .a     (alu_a),
        .b     (alu_b),
        .cur_c (flag_q[FLAG_C]),
        .upd   (flag_upd),
        .nxt   (flag_nxt)
    );

    sf_arith_reg i_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .upd     (flag_upd),
        .nxt     (flag_nxt),
        .q       (flag_q)
    );

    sf_pwr_fsm i_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_up   (pwr_up),
        .wdt_clr  (wdt_clr),
        .halt_cmd (halt_cmd),
        .wdt_tmo  (wdt_tmo),
        .pdf      (pdf),
        .tmo_flag (tmo_flag)
    );

    assign status = {{PAD_W{1'b0}}, tmo_flag, pdf, flag_q};

endmodule

// File: rtl/sf_chk.sv
module sf_chk
    import sf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AUX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               alu_op,
    input  logic [DATA_W-1:0]        alu_a,
    input  logic [DATA_W-1:0]        alu_b,
    input  logic                     wr_en,
    input  logic [NUM_ALU_FLAGS-1:0] wr_data,
    input  logic                     pwr_up,
    input  logic                     wdt_clr,
    input  logic                     halt_cmd,
    input  logic                     wdt_tmo,
    input  logic [STAT_W-1:0]        status
);

    logic quiet_pwr;
    assign quiet_pwr = !pwr_up && !wdt_clr && !halt_cmd && !wdt_tmo;

    // R7
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> status[3:0] == $past(wr_data));

    // R7
    write_keeps_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_pwr |=> $stable(status[5:4]));

    // R5
    logic_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && alu_op >= 4'd5 && alu_op <= 4'd7)
        |=> $stable(status[FLAG_C]) && $stable(status[FLAG_AC])
            && $stable(status[FLAG_OV]));

    // R4
    logic_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && alu_op == 4'd5 && (alu_a & alu_b) == '0) |=> status[FLAG_Z]);

    // R6
    rlc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && alu_op == 4'd8) |=> status[FLAG_C] == $past(alu_a[DATA_W-1]));

    // R9
    halt_pdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_cmd && !pwr_up) |=> status[4]);

    // R10
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tmo && !pwr_up) |=> status[5]);

    // R10
    pwrup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> status[5:4] == 2'b00);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 4'd0 && !wr_en && quiet_pwr) |=> $stable(status));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:6] == 2'b00));

endmodule

bind status_flags sf_chk #(.DATA_W(DATA_W), .AUX_W(AUX_W)) i_chk (.*);

// File: tb/test_status_flags.sv
`timescale 1ns/1ps
module test_status_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alu_op = 4'd0;
    logic [7:0] alu_a = 8'd0;
    logic [7:0] alu_b = 8'd0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       pwr_up = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       halt_cmd = 1'b0;
    logic       wdt_tmo = 1'b0;
    logic [7:0] status;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m = 8'd0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    status_flags i_status_flags (
        .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .wr_en(wr_en), .wr_data(wr_data), .pwr_up(pwr_up), .wdt_clr(wdt_clr),
        .halt_cmd(halt_cmd), .wdt_tmo(wdt_tmo), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_alu(input int op, input int a, input int b,
                                             input logic [3:0] cur);
        logic [3:0] r;
        int cin, s, lo, sa, sb, sr;
        r  = cur;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        case (op)
            1, 2: begin
                cin = (op == 2) ? int'(cur[0]) : 0;
                s  = a + b + cin;
                lo = (a % 16) + (b % 16) + cin;
                sr = sa + sb + cin;
                r[0] = (s > 255);
                r[1] = (lo > 15);
                r[2] = ((s % 256) == 0);
                r[3] = (sr > 127) || (sr < -128);
            end
            3, 4: begin
                cin = (op == 4) ? int'(!cur[0]) : 0;
                s  = a - b - cin;
                lo = (a % 16) - (b % 16) - cin;
                sr = sa - sb - cin;
                r[0] = (s >= 0);
                r[1] = (lo >= 0);
                r[2] = (((s + 256) % 256) == 0);
                r[3] = (sr > 127) || (sr < -128);
            end
            5: r[2] = ((a & b) == 0);
            6: r[2] = ((a | b) == 0);
            7: r[2] = ((a ^ b) == 0);
            8: r[0] = (a >= 128);
            9: r[0] = (a % 2 == 1);
            default: ;
        endcase
        return r;
    endfunction

    // one cycle of stimulus; the bench model follows the requirements
    task automatic step(input string req, input int op, input int a, input int b,
                        input bit we, input logic [3:0] wd,
                        input bit pu, input bit wc, input bit ht, input bit to);
        logic pdf_n, to_n;
        alu_op = op[3:0]; alu_a = a[7:0]; alu_b = b[7:0];
        wr_en = we; wr_data = wd;
        pwr_up = pu; wdt_clr = wc; halt_cmd = ht; wdt_tmo = to;
        if (we) m[3:0] = wd;
        else    m[3:0] = model_alu(op, a, b, m[3:0]);
        pdf_n = m[4]; to_n = m[5];
        if (ht)      begin pdf_n = 1'b1; to_n = 1'b0; end
        else if (wc) begin pdf_n = 1'b0; to_n = 1'b0; end
        if (to) to_n = 1'b1;
        if (pu) begin pdf_n = 1'b0; to_n = 1'b0; end
        m[4] = pdf_n; m[5] = to_n;
        @(negedge clk);
        alu_op = 4'd0; wr_en = 1'b0; pwr_up = 1'b0; wdt_clr = 1'b0;
        halt_cmd = 1'b0; wdt_tmo = 1'b0;
        chk(req, status, m);
    endtask

    task automatic t_reset();
        chk("R11 reset", status, 8'h00);
    endtask

    task automatic t_add();
        step("R1 R3 7F+01", 1, 8'h7F, 8'h01, 0, 0, 0, 0, 0, 0);
        chk("R3 ov set", {7'd0, status[3]}, 8'h01);
        step("R1 R4 FF+01", 1, 8'hFF, 8'h01, 0, 0, 0, 0, 0, 0);
        chk("R4 zero", status, 8'h07);
        step("R1 ADC 12+34+C", 2, 8'h12, 8'h34, 0, 0, 0, 0, 0, 0);
        step("R3 80+80", 1, 8'h80, 8'h80, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_sub();
        step("R2 05-03", 3, 8'h05, 8'h03, 0, 0, 0, 0, 0, 0);
        chk("R2 no borrow", status, 8'h03);
        step("R2 03-05", 3, 8'h03, 8'h05, 0, 0, 0, 0, 0, 0);
        step("R3 80-01", 3, 8'h80, 8'h01, 0, 0, 0, 0, 0, 0);
        chk("R3 sub ov", status, 8'h09);
        step("R2 R4 10-10", 3, 8'h10, 8'h10, 0, 0, 0, 0, 0, 0);
        step("R2 clear C", 0, 0, 0, 1, 4'h0, 0, 0, 0, 0);
        step("R2 SBC 05-05-1", 4, 8'h05, 8'h05, 0, 0, 0, 0, 0, 0);
        chk("R2 sbc borrow", status, 8'h00);
        step("R2 SBC 09-02", 4, 8'h09, 8'h02, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_logic();
        step("R7 preset", 0, 0, 0, 1, 4'hB, 0, 0, 0, 0);
        step("R5 AND zero", 5, 8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0);
        chk("R5 others kept", status, 8'h0F);
        step("R5 OR nonzero", 6, 8'h00, 8'h20, 0, 0, 0, 0, 0, 0);
        step("R4 XOR equal", 7, 8'h5A, 8'h5A, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rotate();
        step("R6 preset", 0, 0, 0, 1, 4'hE, 0, 0, 0, 0);
        step("R6 RLC msb", 8, 8'h80, 8'h00, 0, 0, 0, 0, 0, 0);
        chk("R6 rlc", status, 8'h0F);
        step("R6 RRC lsb0", 9, 8'h02, 8'hFF, 0, 0, 0, 0, 0, 0);
        step("R6 RRC lsb1", 9, 8'h01, 8'h00, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_write();
        step("R9 halt", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        step("R7 write keeps PDF", 0, 0, 0, 1, 4'h5, 0, 0, 0, 0);
        chk("R7 write", status, 8'h15);
        step("R8 write beats add", 1, 8'hFF, 8'h01, 1, 4'h0, 0, 0, 0, 0);
        chk("R8 precedence", status, 8'h10);
        step("R8 write beats rotate", 8, 8'h80, 8'h00, 1, 4'h8, 0, 0, 0, 0);
    endtask

    task automatic t_power();
        step("R9 wdt clear", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("R9 clr", status & 8'h30, 8'h00);
        step("R10 timeout", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10 halt clears TO", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R10 halt", status & 8'h30, 8'h10);
        step("R10 timeout while halted", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10 wdt clr vs timeout", 0, 0, 0, 0, 0, 0, 1, 0, 1);
        chk("R10 tmo wins", status & 8'h30, 8'h20);
        step("R10 halt with timeout", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        step("R10 power-up beats all", 0, 0, 0, 0, 0, 1, 1, 1, 1);
        chk("R10 pwr", status & 8'h30, 8'h00);
        step("R9 halt beats clr", 0, 0, 0, 0, 0, 0, 1, 1, 0);
        step("R9 power-up", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_idle();
        step("R12 preset", 0, 0, 0, 1, 4'h9, 0, 0, 1, 0);
        step("R12 none", 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0);
        step("R12 code 12", 12, 8'hFF, 8'h01, 0, 0, 0, 0, 0, 0);
        step("R12 code 15", 15, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0);
        chk("R12 held", status, 8'h19);
        chk("R11 top bits", status & 8'hC0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_rotate();
        t_write();
        t_power();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule